// File: doc/BRIEF.md
# Pipelined Read-Modify-Write Table Bank

This bank stores narrow table entries packed into wide rows and updates them through a three-stage read-modify-write pipeline. It accepts one request every clock. Each request names one entry, an operation and an operand. The operations are write operand, keep (a refresh), increment and decrement. The pipeline decodes the entry address in the first stage and reads the whole row in the second. In the third stage it patches the selected entry and writes the full row back to the array.

The bank holds two copies of the stage resources: a decode register, a row latch and a modify unit. A free-running one-bit toggle picks which copy a request enters, so requests in adjacent cycles always use different copies. This lets a read of one row overlap the write-back of another in the same cycle. Because many entries share a row, the row a request reads can be the row its predecessor is writing back. In that case the read takes the predecessor's patched row instead of the stale array contents. The read value comes back on the response port two cycles after the request is accepted. The patched entry is presented at the same time on the write-back port.

Top module: `rmw_bank`

## Requirements
- R1: While reset is asserted, and in the cycles after it before any request has been accepted, rsp_valid and wb_valid are both 0.
- R2: The entry address is {row, slot}: the upper 7 bits pick one of 128 rows of 256 bits, and the lower 4 bits pick one of 16 slots of 16 bits. Slot s occupies row bits [16s+15:16s]. Updating one slot leaves the other slots of the same row unchanged.
- R3: A request accepted in cycle c gives rsp_valid and wb_valid high in cycle c+2 and only then. A cycle without a request gives both low two cycles later.
- R4: rsp_data is the value the entry held before this request's modification, including the effect of every earlier request.
- R5: Operation code 2'b00 replaces the entry with req_operand.
- R6: Operation code 2'b01 (keep, used as refresh) writes the row back unchanged, and wb_data equals rsp_data.
- R7: Operation code 2'b10 adds one to the entry, and 2'b11 subtracts one. Both wrap modulo 2^16.
- R8: Requests in adjacent cycles that touch the same row, including the same entry, give the same results as if each ran to completion before the next started.
- R9: A new request is accepted in every cycle with no stall, so one request completes per clock.
- R10: wb_addr equals the address of the request whose result is on wb_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | 11 | Entry address {row, slot} |
| req_op | input | 2 | 00 write, 01 keep, 10 increment, 11 decrement |
| req_operand | input | 16 | Value used by the write operation |
| rsp_valid | output | 1 | rsp_data carries a read result |
| rsp_data | output | 16 | Entry value before modification |
| wb_valid | output | 1 | Write-back result is present |
| wb_addr | output | 11 | Entry address being written back |
| wb_data | output | 16 | Entry value after modification |

## Verification
In any cycle, one request reads a row while the request before it writes a row back. When both touch the same row, the forwarding path decides what the reader sees. This case is forced on every cycle by a full sweep that writes all slots of each row in consecutive cycles. A long random run confined to two rows, with mixed operations and occasional idle gaps, provokes it further, including repeated updates of a single entry. All read and write-back values are checked against an entry-level model kept in the bench. A later keep sweep over every address shows whether any earlier forwarded update was lost.

// File: rtl/rmw_bank.sv
module rmw_bank #(
  parameter int ROWS  = 128,
  parameter int ROW_W = 256,
  parameter int ENT_W = 16,
  localparam int SLOTS   = ROW_W / ENT_W,
  localparam int SLOT_AW = $clog2(SLOTS),
  localparam int ROW_AW  = $clog2(ROWS),
  localparam int ADDR_W  = ROW_AW + SLOT_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  input  logic [ENT_W-1:0]  req_operand,
  output logic              rsp_valid,
  output logic [ENT_W-1:0]  rsp_data,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [ENT_W-1:0]  wb_data
);

  localparam logic [1:0] OP_WR   = 2'b00;
  localparam logic [1:0] OP_KEEP = 2'b01;
  localparam logic [1:0] OP_INC  = 2'b10;
  localparam logic [1:0] OP_DEC  = 2'b11;

  logic [ROW_W-1:0] mem [ROWS];

  // set tog: decode capture and write-back; set ~tog: row read
  logic tog;

  logic              dec_v    [2];
  logic [ROW_AW-1:0] dec_row  [2];
  logic [SLOT_AW-1:0] dec_col [2];
  logic [1:0]        dec_op   [2];
  logic [ENT_W-1:0]  dec_opnd [2];

  logic              lat_v    [2];
  logic [ROW_AW-1:0] lat_row  [2];
  logic [SLOT_AW-1:0] lat_col [2];
  logic [1:0]        lat_op   [2];
  logic [ENT_W-1:0]  lat_opnd [2];
  logic [ROW_W-1:0]  lat_data [2];

  logic [ENT_W-1:0] cur_ent, mod_ent;
  logic [ROW_W-1:0] new_row, rd_src;
  logic             fwd;

  always_comb begin
    cur_ent = lat_data[tog][lat_col[tog]*ENT_W +: ENT_W];
    case (lat_op[tog])
      OP_WR:   mod_ent = lat_opnd[tog];
      OP_KEEP: mod_ent = cur_ent;
      OP_INC:  mod_ent = cur_ent + ENT_W'(1);
      default: mod_ent = cur_ent - ENT_W'(1);
    endcase
    new_row = lat_data[tog];
    new_row[lat_col[tog]*ENT_W +: ENT_W] = mod_ent;
  end

  assign fwd    = lat_v[tog] && (lat_row[tog] == dec_row[~tog]);
  assign rd_src = fwd ? new_row : mem[dec_row[~tog]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog <= 1'b0;
      for (int s = 0; s < 2; s++) begin
        dec_v[s]    <= 1'b0;
        dec_row[s]  <= '0;
        dec_col[s]  <= '0;
        dec_op[s]   <= '0;
        dec_opnd[s] <= '0;
        lat_v[s]    <= 1'b0;
        lat_row[s]  <= '0;
        lat_col[s]  <= '0;
        lat_op[s]   <= '0;
        lat_opnd[s] <= '0;
        lat_data[s] <= '0;
      end
    end else begin
      tog <= ~tog;
      for (int s = 0; s < 2; s++) begin
        if (tog == 1'(s)) begin
          dec_v[s] <= req_valid;
          if (req_valid) begin
            dec_row[s]  <= req_addr[ADDR_W-1:SLOT_AW];
            dec_col[s]  <= req_addr[SLOT_AW-1:0];
            dec_op[s]   <= req_op;
            dec_opnd[s] <= req_operand;
          end
        end else begin
          lat_v[s] <= dec_v[s];
          if (dec_v[s]) begin
            lat_row[s]  <= dec_row[s];
            lat_col[s]  <= dec_col[s];
            lat_op[s]   <= dec_op[s];
            lat_opnd[s] <= dec_opnd[s];
            lat_data[s] <= rd_src;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (lat_v[tog]) mem[lat_row[tog]] <= new_row;
  end

  assign rsp_valid = lat_v[tog];
  assign rsp_data  = cur_ent;
  assign wb_valid  = lat_v[tog];
  assign wb_addr   = {lat_row[tog], lat_col[tog]};
  assign wb_data   = mod_ent;

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##2 rsp_valid);

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ##2 !wb_valid);

  p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(req_valid && req_op == OP_WR, 2)) |-> wb_data == $past(req_operand, 2));

  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(req_valid && req_op == OP_KEEP, 2)) |-> wb_data == rsp_data);

  p_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(req_valid && req_op == OP_INC, 2)) |-> wb_data == rsp_data + ENT_W'(1));

  p_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(req_valid && req_op == OP_DEC, 2)) |-> wb_data == rsp_data - ENT_W'(1));

  p_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(req_valid, 2)) |-> wb_addr == $past(req_addr, 2));

endmodule

// File: tb/sim_rmw_bank.sv
module sim_rmw_bank;
  localparam int AW = 11;
  localparam int N  = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_op = '0;
  logic [15:0] req_operand = '0;
  logic rsp_valid, wb_valid;
  logic [15:0] rsp_data, wb_data;
  logic [AW-1:0] wb_addr;

  always #2 clk = ~clk;

  rmw_bank u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .req_operand(req_operand), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] model [N];
  bit known [N];

  bit p1_v, p2_v, p1_kr, p2_kr, p1_kw, p2_kw;
  logic [AW-1:0] p1_a, p2_a;
  logic [15:0] p1_rd, p2_rd, p1_wb, p2_wb;
  string p1_tag, p2_tag;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] nxt(input logic [1:0] op, input logic [15:0] e, input logic [15:0] d);
    case (op)
      2'b00:   return d;
      2'b01:   return e;
      2'b10:   return e + 16'd1;
      default: return e - 16'd1;
    endcase
  endfunction

  function automatic string optag(input logic [1:0] op);
    case (op)
      2'b00:   return "R5";
      2'b01:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic cyc(input bit v, input logic [AW-1:0] a, input logic [1:0] op,
                     input logic [15:0] d, input string tag);
    @(negedge clk);
    if (p2_v) begin
      chk(rsp_valid === 1'b1 && wb_valid === 1'b1, "R3 valid after request",
          {30'd0, rsp_valid, wb_valid}, 32'h3);
      if (p2_kr) chk(rsp_data === p2_rd, {p2_tag, " R4 read data"}, rsp_data, p2_rd);
      chk(wb_addr === p2_a, "R10 write-back address", wb_addr, p2_a);
      if (p2_kw) chk(wb_data === p2_wb, {p2_tag, " write-back data"}, wb_data, p2_wb);
    end else begin
      chk(rsp_valid === 1'b0 && wb_valid === 1'b0, "R3 idle slot",
          {30'd0, rsp_valid, wb_valid}, 32'h0);
    end
    p2_v = p1_v; p2_a = p1_a; p2_rd = p1_rd; p2_wb = p1_wb;
    p2_kr = p1_kr; p2_kw = p1_kw; p2_tag = p1_tag;
    p1_v = v; p1_a = a;
    if (v) begin
      p1_rd  = model[a];
      p1_kr  = known[a];
      p1_wb  = nxt(op, model[a], d);
      p1_kw  = known[a] || (op == 2'b00);
      p1_tag = {tag, " ", optag(op)};
      model[a] = p1_wb;
      known[a] = p1_kw;
    end
    req_valid = v; req_addr = a; req_op = op; req_operand = d;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin model[i] = '0; known[i] = 1'b0; end
    p1_v = 0; p2_v = 0;
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0 && wb_valid === 1'b0, "R1 outputs in reset",
        {30'd0, rsp_valid, wb_valid}, 32'h0);
    rst_n = 1'b1;
    cyc(0, '0, 2'b00, '0, "R1");
    cyc(0, '0, 2'b00, '0, "R1");

    // fill every slot, consecutive slots of a row back to back
    for (int i = 0; i < N; i++)
      cyc(1, AW'(i), 2'b00, 16'(i * 40503 + 7), "R9 R8 fill");

    // keep sweep downward: every slot must retain its own value
    for (int i = N - 1; i >= 0; i--)
      cyc(1, AW'(i), 2'b01, 16'hDEAD, "R2 keep sweep");

    // wrap and same-entry chains
    cyc(1, 11'h123, 2'b00, 16'hFFFF, "R7 wrap");
    cyc(1, 11'h123, 2'b10, 16'h0, "R7 wrap R8");
    cyc(1, 11'h123, 2'b11, 16'h0, "R7 wrap R8");
    cyc(1, 11'h123, 2'b11, 16'h0, "R7 wrap R8");
    cyc(1, 11'h124, 2'b10, 16'h0, "R2 neighbour");
    cyc(0, '0, 2'b00, '0, "R3");
    cyc(1, 11'h123, 2'b10, 16'h0, "R7 after gap");

    // random traffic on two rows
    void'($urandom(32'h1a2b3c));
    for (int i = 0; i < 5000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[3:0] != 4'd0, {7'(5 + r[4]), r[8:5]}, r[10:9], r[31:16], "R8 random");
    end

    for (int i = 0; i < N; i += 97)
      cyc(1, AW'(i), 2'b01, 16'h0, "R6 final");
    cyc(0, '0, 2'b00, '0, "R3");
    cyc(0, '0, 2'b00, '0, "R3");
    cyc(0, '0, 2'b00, '0, "R3");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule